// File: doc/BRIEF.md
# Dual-Read Register File

This block holds the thirty-two general registers of a small 32-bit processor that spends two cycles on each instruction. The decode stage presents two source indices and gets both operands back in the same cycle through two independent, purely combinational read ports. The writeback stage presents one destination index, a data word and an enable, and the word is captured on the next rising clock edge.

Index zero is hard-wired: it holds no storage, any write aimed at it is dropped, and it always reads as zero. Five extra outputs show the contents of registers 16, 17, 18, 29 and 31 at all times, so a bench can watch the working registers, the stack pointer and the return address without using the read ports.

There is no forwarding from the write port to the read ports. A read of a register that is being written in the same cycle gives the stored value until the clock edge has passed. A synchronous active-high reset clears every register, so simulation starts from a known state.

Top module: `dualReadRegFile`

## Requirements
- R1: When `wrEn` is 1 and `wrAddr` is nonzero, `wrData` is stored into register `wrAddr` on the rising clock edge and reads back from that index after the edge.
- R2: A write changes only the addressed register. Every other register keeps its value.
- R3: A write with `wrAddr` = 0 is discarded, and index 0 reads as 0x00000000 on both read ports at all times.
- R4: `rdDataA` presents the register selected by `rdAddrA`, and `rdDataB` presents the register selected by `rdAddrB`. Each port is combinational and does not depend on the other port's address.
- R5: `dbgSave0`, `dbgSave1`, `dbgSave2`, `dbgStack` and `dbgLink` always present registers 16, 17, 18, 29 and 31, in that order.
- R6: When `rst` is 1 at a rising edge, every register becomes zero. Reset takes priority over a write in the same cycle.
- R7: When `wrEn` is 0, no register changes, whatever `wrAddr` and `wrData` hold.
- R8: Before the edge that captures a write, a read of the register being written returns its old value. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. It drives the storage directly and is not gated. |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Index of the register to write |
| wrData | input | 32 | Word to write |
| rdAddrA | input | 5 | Index for read port A |
| rdAddrB | input | 5 | Index for read port B |
| rdDataA | output | 32 | Value of the register at `rdAddrA` |
| rdDataB | output | 32 | Value of the register at `rdAddrB` |
| dbgSave0 | output | 32 | Register 16 |
| dbgSave1 | output | 32 | Register 17 |
| dbgSave2 | output | 32 | Register 18 |
| dbgStack | output | 32 | Register 29 |
| dbgLink | output | 32 | Register 31 |

## Verification
The assertions check every cycle that:
- an enabled write to a nonzero index lands in the selected register;
- every unselected register holds its value;
- no register is selected while `wrEn` is 0;
- index 0 reads as zero on both ports.

Only the bench scenarios can show:
- that reset clears the whole file;
- that the two read ports stay independent across different address pairs;
- that the debug outputs map to the right indices;
- that a read in the cycle of a write returns the old value (no forwarding).

The bench does this by comparing all seven outputs with a behavioural model both before and after each edge.

// File: rtl/regFilePkg.sv
package regFilePkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int NUM_REGS = 2 ** ADDR_W;

  // Indices exposed on the fixed debug outputs
  localparam int DBG_S0 = 16;
  localparam int DBG_S1 = 17;
  localparam int DBG_S2 = 18;
  localparam int DBG_SP = 29;
  localparam int DBG_RA = 31;

  // Strobes from the write control to the storage datapath
  typedef struct packed {
    logic                clearAll;
    logic [NUM_REGS-1:0] wrSel;
  } regStrobes_t;
endpackage

// File: rtl/regWriteCtrl.sv
module regWriteCtrl
  import regFilePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output regStrobes_t       strobes
);

  always_comb begin
    strobes.clearAll = rst;
    strobes.wrSel    = '0;
    if (wrEn && (wrAddr != '0)) begin
      strobes.wrSel[wrAddr] = 1'b1;
    end
  end

  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (strobes.wrSel == '0)); // R7

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes.wrSel)); // R2

  AST_SELECT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrAddr != '0)) |-> strobes.wrSel[wrAddr]); // R1

endmodule

// File: rtl/regArray.sv
module regArray
  import regFilePkg::*;
(
  input  logic              clk,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] dbgSave0,
  output logic [DATA_W-1:0] dbgSave1,
  output logic [DATA_W-1:0] dbgSave2,
  output logic [DATA_W-1:0] dbgStack,
  output logic [DATA_W-1:0] dbgLink
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gEntry
    if (i == 0) begin : gZero
      assign regs[0] = '0;
    end else begin : gStore
      always_ff @(posedge clk) begin
        if (strobes.clearAll) begin
          regs[i] <= '0;
        end else if (strobes.wrSel[i]) begin
          regs[i] <= wrData;
        end
      end

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (strobes.clearAll)
        strobes.wrSel[i] |=> (regs[i] == $past(wrData))); // R1

      AST_UNSELECTED_HOLDS: assert property (@(posedge clk) disable iff (strobes.clearAll)
        !strobes.wrSel[i] |=> $stable(regs[i])); // R2
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  assign dbgSave0 = regs[DBG_S0];
  assign dbgSave1 = regs[DBG_S1];
  assign dbgSave2 = regs[DBG_S2];
  assign dbgStack = regs[DBG_SP];
  assign dbgLink  = regs[DBG_RA];

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (rdAddrA == '0) |-> (rdDataA == '0)); // R3

  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (rdAddrB == '0) |-> (rdDataB == '0)); // R3

endmodule

// File: rtl/dualReadRegFile.sv
module dualReadRegFile
  import regFilePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] dbgSave0,
  output logic [DATA_W-1:0] dbgSave1,
  output logic [DATA_W-1:0] dbgSave2,
  output logic [DATA_W-1:0] dbgStack,
  output logic [DATA_W-1:0] dbgLink
);

  regStrobes_t strobes;

  regWriteCtrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobes (strobes)
  );

  regArray i_array (
    .clk      (clk),
    .strobes  (strobes),
    .wrData   (wrData),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .rdDataA  (rdDataA),
    .rdDataB  (rdDataB),
    .dbgSave0 (dbgSave0),
    .dbgSave1 (dbgSave1),
    .dbgSave2 (dbgSave2),
    .dbgStack (dbgStack),
    .dbgLink  (dbgLink)
  );

endmodule

// File: tb/test_dualReadRegFile.sv
`timescale 1ns/1ps
module test_dualReadRegFile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdAddrA = '0;
  logic [4:0]  rdAddrB = '0;
  logic [31:0] rdDataA, rdDataB, dbgSave0, dbgSave1, dbgSave2, dbgStack, dbgLink;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  dualReadRegFile i_dualReadRegFile (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .dbgSave0(dbgSave0), .dbgSave1(dbgSave1), .dbgSave2(dbgSave2),
    .dbgStack(dbgStack), .dbgLink(dbgLink)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " portA"}, rdDataA, model[rdAddrA]);
    check({tag, " portB"}, rdDataB, model[rdAddrB]);
    check("R5 dbg16", dbgSave0, model[16]);
    check("R5 dbg17", dbgSave1, model[17]);
    check("R5 dbg18", dbgSave2, model[18]);
    check("R5 dbg29", dbgStack, model[29]);
    check("R5 dbg31", dbgLink,  model[31]);
  endtask

  // One clock: apply inputs after the falling edge, compare before and after the rising edge
  task automatic doCycle(input logic r, input logic we, input logic [4:0] wa,
                         input logic [31:0] wd, input logic [4:0] ra,
                         input logic [4:0] rb, input string tag);
    rst = r; wrEn = we; wrAddr = wa; wrData = wd; rdAddrA = ra; rdAddrB = rb;
    #1;
    checkAll({tag, " pre-edge"});
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < 32; k++) model[k] = '0;
    end else if (we && wa != 0) begin
      model[wa] = wd;
    end
    @(negedge clk);
    #0.5;
    checkAll({tag, " post-edge"});
  endtask

  task automatic readAll(input string tag);
    for (int k = 0; k < 32; k++) begin
      doCycle(1'b0, 1'b0, 5'(k), 32'hDEAD_0000 | k, 5'(k), 5'(31 - k), tag);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) model[k] = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    // R6: the file is clear after reset
    doCycle(1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R6");
    readAll("R6");
    // R1: fill every register with a distinct pattern
    for (int k = 0; k < 32; k++) begin
      doCycle(1'b0, 1'b1, 5'(k), 32'hA5A5_0000 ^ (32'h1357_9BDF * k), 5'(k), 5'((k + 1) % 32), "R1");
    end
    readAll("R2");
    // R3: writes to index 0 are discarded
    doCycle(1'b0, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R3");
    doCycle(1'b0, 1'b1, 5'd0, 32'h1234_5678, 5'd0, 5'd7, "R3");
    // R7: no write when disabled, whatever the address and data
    for (int k = 0; k < 32; k++) begin
      doCycle(1'b0, 1'b0, 5'(k), ~32'(k), 5'(k), 5'(k), "R7");
    end
    readAll("R7");
    // R8: a read of the register being written returns the old value before the edge
    doCycle(1'b0, 1'b1, 5'd5, 32'hCAFE_F00D, 5'd5, 5'd5, "R8");
    doCycle(1'b0, 1'b0, 5'd5, 32'h0, 5'd5, 5'd6, "R8");
    // R5: the debug indices
    doCycle(1'b0, 1'b1, 5'd16, 32'h1616_1616, 5'd16, 5'd0, "R5");
    doCycle(1'b0, 1'b1, 5'd17, 32'h1717_1717, 5'd17, 5'd0, "R5");
    doCycle(1'b0, 1'b1, 5'd18, 32'h1818_1818, 5'd18, 5'd0, "R5");
    doCycle(1'b0, 1'b1, 5'd29, 32'h2929_2929, 5'd29, 5'd0, "R5");
    doCycle(1'b0, 1'b1, 5'd31, 32'h3131_3131, 5'd31, 5'd0, "R5");
    doCycle(1'b0, 1'b1, 5'd30, 32'h3030_3030, 5'd30, 5'd19, "R5");
    // R4: independent address pairs on the two read ports
    for (int a = 0; a < 32; a += 3) begin
      for (int b = 0; b < 32; b += 5) begin
        doCycle(1'b0, 1'b0, 5'd0, 32'h0, 5'(a), 5'(b), "R4");
      end
    end
    // R6: reset wins over a simultaneous write
    doCycle(1'b1, 1'b1, 5'd9, 32'h9999_9999, 5'd9, 5'd31, "R6");
    readAll("R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule